// File: doc/BRIEF.md
# USB Token CRC5 Parallel Engine

This block computes the 5-bit cyclic redundancy code that protects a USB token, using the generator x^5 + x^2 + 1 (0x05). It takes the complete 11-bit token payload, which is address plus endpoint, in one clock cycle. It also works as a checker: it compares the code it computed with a 5-bit code received from the line. The next-state logic is a flat XOR network. Its result equals eleven steps of the bit-serial shift register, with the highest-index data bit entering first.

A protocol engine uses the block in two ways. To build a token, it pulses `start` together with the first valid word and reads `crc_tx`, which is the bitwise inverse of the register. To check a token, it also raises `check_en` and presents the received code on `rx_crc`. `match` then reports the result one cycle later. A `start` pulse reloads the all-ones seed, so tokens can follow each other with no reset between them.

Top module: `crc5_token_engine`

## Requirements
- R1: While `rst_n` is low, whether or not a clock edge occurs, `crc_state` is 5'h1F and `match` is 0.
- R2: On a rising edge with `valid`=1 and `start`=0, `crc_state` becomes the value the serial step gives when it is applied once per bit of `data`. The bits enter from bit 10 down to bit 0. The serial step from state c with input bit d is: n0=c4^d, n1=c0, n2=c1^c4^d, n3=c2, n4=c3.
- R3: On a rising edge with `valid`=0 and `start`=0, `crc_state` holds its value. `data`, `rx_crc` and `check_en` have no effect on it.
- R4: On a rising edge with `start`=1 and `valid`=0, `crc_state` becomes 5'h1F.
- R5: On a rising edge with `start`=1 and `valid`=1, `crc_state` becomes the R2 result computed from the seed 5'h1F, not from the old state.
- R6: `crc_tx` always equals the bitwise inverse of `crc_state`.
- R7: After a rising edge with `valid`=1 and `check_en`=1, `match` is 1 exactly when the inverse of the new `crc_state` equals the `rx_crc` sampled at that edge.
- R8: After a rising edge where `valid` or `check_en` is 0, `match` is 0. This holds even when `rx_crc` equals `crc_tx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, seeds all ones |
| start | input | 1 | Reload the seed before or with the first word of a token |
| valid | input | 1 | Data word present this cycle |
| check_en | input | 1 | Compare the result against `rx_crc` |
| data | input | 11 | Token payload, bit 10 enters the register first |
| rx_crc | input | 5 | Received code, as transmitted (inverted form) |
| crc_state | output | 5 | Running CRC register |
| crc_tx | output | 5 | Code to transmit, inverse of `crc_state` |
| match | output | 1 | Registered compare result |

## Verification
The hardest case to reach from the ports is a positive `match`. It needs `rx_crc` to equal the inverse of a result that has not been computed yet, and random codes hit it only one time in 32. The bench therefore runs its own bit-serial model ahead of the edge and drives that exact code on `rx_crc`. It then flips a single bit of it for the negative case. A second case is `start` and `valid` arriving together on top of a state that is not the seed. Reaching it needs a token that leaves a non-seed state behind, followed immediately by a merged start-and-word cycle.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  localparam int CRC_W  = 5;
  localparam int DATA_W = 11;
  localparam logic [CRC_W-1:0] POLY = 5'h05;
  localparam logic [CRC_W-1:0] SEED = '1;

  // one shift of the serial register with input bit din
  function automatic logic [CRC_W-1:0] lfsr_step(input logic [CRC_W-1:0] cur,
                                                 input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  // whole word, highest index first
  function automatic logic [CRC_W-1:0] lfsr_word(input logic [CRC_W-1:0] cur,
                                                 input logic [DATA_W-1:0] word);
    logic [CRC_W-1:0] acc;
    acc = cur;
    for (int b = DATA_W - 1; b >= 0; b--) acc = lfsr_step(acc, word[b]);
    return acc;
  endfunction

  // data bits feeding output bit idx when the state is zero
  function automatic logic [DATA_W-1:0] data_tap(input int idx);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < DATA_W; j++) begin
      logic [DATA_W-1:0] oh;
      logic [CRC_W-1:0]  r;
      oh = '0;
      oh[j] = 1'b1;
      r = lfsr_word('0, oh);
      m[j] = r[idx];
    end
    return m;
  endfunction

  // state bits feeding output bit idx when the data is zero
  function automatic logic [CRC_W-1:0] state_tap(input int idx);
    logic [CRC_W-1:0] m;
    m = '0;
    for (int k = 0; k < CRC_W; k++) begin
      logic [CRC_W-1:0] oh;
      logic [CRC_W-1:0] r;
      oh = '0;
      oh[k] = 1'b1;
      r = lfsr_word(oh, '0);
      m[k] = r[idx];
    end
    return m;
  endfunction
endpackage

// File: rtl/crc5_next_state.sv
module crc5_next_state
  import crc5_pkg::*;
#(
  parameter bit FLAT = 1'b1
) (
  input  logic [CRC_W-1:0]  cur,
  input  logic [DATA_W-1:0] word,
  output logic [CRC_W-1:0]  nxt
);
  generate
    if (FLAT) begin : g_flat
      // linear split: data-only term xor state-only term
      logic [CRC_W-1:0] data_term;
      logic [CRC_W-1:0] state_term;
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        localparam logic [DATA_W-1:0] DMASK = data_tap(i);
        localparam logic [CRC_W-1:0]  SMASK = state_tap(i);
        assign data_term[i]  = ^(word & DMASK);
        assign state_term[i] = ^(cur & SMASK);
      end
      assign nxt = data_term ^ state_term;
    end else begin : g_chain
      logic [CRC_W-1:0] stage [DATA_W+1];
      assign stage[0] = cur;
      for (genvar k = 0; k < DATA_W; k++) begin : g_step
        assign stage[k+1] = lfsr_step(stage[k], word[DATA_W-1-k]);
      end
      assign nxt = stage[DATA_W];
    end
  endgenerate
endmodule

// File: rtl/crc5_state_reg.sv
module crc5_state_reg
  import crc5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             load,
  input  logic [CRC_W-1:0] nxt,
  output logic [CRC_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= SEED;
    else if (load)   state <= nxt;
    else if (reload) state <= SEED;
  end
endmodule

// File: rtl/crc5_match_stage.sv
module crc5_match_stage
  import crc5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compare,
  input  logic [CRC_W-1:0] nxt,
  input  logic [CRC_W-1:0] rx_crc,
  output logic             match
);
  logic equal;
  assign equal = ((~nxt) == rx_crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match <= 1'b0;
    else        match <= compare & equal;
  end
endmodule

// File: rtl/crc5_token_engine.sv
module crc5_token_engine
  import crc5_pkg::*;
#(
  parameter bit FLAT_NET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              valid,
  input  logic              check_en,
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  rx_crc,
  output logic [CRC_W-1:0]  crc_state,
  output logic [CRC_W-1:0]  crc_tx,
  output logic              match
);
  // named internal events
  logic             word_fire;
  logic             chk_fire;
  logic [CRC_W-1:0] base_state;
  logic [CRC_W-1:0] nxt_state;

  assign word_fire  = valid;
  assign chk_fire   = valid & check_en;
  assign base_state = start ? SEED : crc_state;

  crc5_next_state #(.FLAT(FLAT_NET)) u_net (
    .cur  (base_state),
    .word (data),
    .nxt  (nxt_state)
  );

  crc5_state_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (start),
    .load   (word_fire),
    .nxt    (nxt_state),
    .state  (crc_state)
  );

  crc5_match_stage u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .compare (chk_fire),
    .nxt     (nxt_state),
    .rx_crc  (rx_crc),
    .match   (match)
  );

  assign crc_tx = ~crc_state;
endmodule

// File: rtl/crc5_token_checker.sv
module crc5_token_checker
  import crc5_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              valid,
  input logic              check_en,
  input logic [DATA_W-1:0] data,
  input logic [CRC_W-1:0]  rx_crc,
  input logic [CRC_W-1:0]  crc_state,
  input logic              match
);
  // R1: reset contents, checked between edges
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_seed: assert (crc_state == SEED && !match);
    end
  end

  a_r2_word_update: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> crc_state == lfsr_word($past(crc_state), $past(data)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> $stable(crc_state));

  a_r4_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> crc_state == SEED);

  a_r5_start_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    (start && valid) |=> crc_state == lfsr_word(SEED, $past(data)));

  a_r7_match_value: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && check_en) |=> match == ((~crc_state) == $past(rx_crc)));

  a_r8_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && check_en) |=> !match);
endmodule

bind crc5_token_engine crc5_token_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .valid     (valid),
  .check_en  (check_en),
  .data      (data),
  .rx_crc    (rx_crc),
  .crc_state (crc_state),
  .match     (match)
);

// File: tb/test_crc5_token_engine.sv
module test_crc5_token_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic        check_en = 1'b0;
  logic [10:0] data = '0;
  logic [4:0]  rx_crc = '0;
  logic [4:0]  crc_state;
  logic [4:0]  crc_tx;
  logic        match;

  int checks = 0;
  int fails  = 0;
  int model_state = 31;
  int model_match = 0;

  always #10 clk = ~clk;

  crc5_token_engine i_crc5_token_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
    .check_en(check_en), .data(data), .rx_crc(rx_crc),
    .crc_state(crc_state), .crc_tx(crc_tx), .match(match)
  );

  // bit-serial reference, integer arithmetic
  function automatic int ref_word(input int st, input int word);
    int s;
    s = st;
    for (int b = 10; b >= 0; b--) begin
      int fb;
      fb = ((s >> 4) & 1) ^ ((word >> b) & 1);
      s = (s * 2) % 32;
      if (fb != 0) s = s ^ 5;
    end
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, update the model, compare after the edge
  task automatic cycle(input bit st, input bit vl, input bit ce,
                       input int word, input int rx, input string req);
    int base;
    @(negedge clk);
    start = st; valid = vl; check_en = ce;
    data = word[10:0]; rx_crc = rx[4:0];
    base = st ? 31 : model_state;
    if (vl) model_state = ref_word(base, word);
    else if (st) model_state = 31;
    model_match = (vl && ce && (((~model_state) & 31) == rx)) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    check({req, " state"}, int'(crc_state), model_state);
    check("R6 tx inverse", int'(crc_tx), (~model_state) & 31);
    check({req, " match"}, int'(match), model_match);
    start = 0; valid = 0; check_en = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    int w, good;
    #25;
    check("R1 reset state", int'(crc_state), 31);
    check("R1 reset match", int'(match), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2 words from seed and chained
    cycle(0, 1, 0, 11'h000, 0, "R2 zero word");
    cycle(0, 1, 0, 11'h7FF, 0, "R2 ones word");
    cycle(0, 1, 0, 11'h400, 0, "R2 msb only");
    cycle(0, 1, 0, 11'h001, 0, "R2 lsb only");
    for (int i = 0; i < 40; i++) cycle(0, 1, 0, $urandom_range(0, 2047), 0, "R2 random");

    // R3 idle with busy inputs
    cycle(0, 0, 1, 11'h5A5, (~model_state) & 31, "R3 hold");
    cycle(0, 0, 0, 11'h2AA, 7, "R3 hold");

    // R4 reload alone
    cycle(1, 0, 0, 11'h123, 0, "R4 reload");
    cycle(0, 1, 0, 11'h3C3, 0, "R2 after reload");

    // R5 start with word on a non-seed state
    cycle(1, 1, 0, 11'h1B7, 0, "R5 merged start");
    cycle(1, 1, 0, 11'h1B7, 0, "R5 repeat token");

    // R7 checks with correct and corrupted codes, back-to-back tokens
    for (int i = 0; i < 60; i++) begin
      w = $urandom_range(0, 2047);
      good = (~ref_word(31, w)) & 31;
      cycle(1, 1, 1, w, good, "R7 correct code");
      w = $urandom_range(0, 2047);
      good = (~ref_word(31, w)) & 31;
      cycle(1, 1, 1, w, good ^ (1 << (i % 5)), "R7 bad code");
    end

    // R8 compare disabled with correct code, and check_en without valid
    w = 11'h6E1;
    good = (~ref_word(31, w)) & 31;
    cycle(1, 1, 0, w, good, "R8 no check_en");
    cycle(0, 0, 1, 0, (~model_state) & 31, "R8 no valid");

    // R1 asynchronous reset mid-run, between edges
    cycle(0, 1, 0, 11'h0F0, 0, "R2 pre reset");
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async state", int'(crc_state), 31);
    check("R1 async match", int'(match), 0);
    model_state = 31;
    @(negedge clk);
    rst_n = 1'b1;
    cycle(0, 1, 1, 11'h2D4, (~ref_word(31, 11'h2D4)) & 31, "R7 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule